// File: doc/BRIEF.md
# Two-Stage Latch/Register Bus Transceiver Datapath

This block is a non-inverting datapath of parameterised width (ten bits by default). Data enters on an input-only port A. A first storage stage forwards it to an open-drain backplane port B. A second storage stage delivers data to a push-pull output port C. Each stage has its own mode select, its own strobe and its own active-low output enable.

In register mode a stage captures its input on a rising strobe. In latch mode a stage passes its input straight through while the strobe is high, and keeps it once the strobe drops. A route select feeds the second stage either from the resolved backplane value or from an internal tap on the first stage. This lets A data reach C for diagnostics without driving the backplane.

The block runs on one system clock, and both strobes are sampled synchronous inputs. The backplane port is split at the pad boundary:
- a per-bit pull-low request goes out to the pad;
- the resolved wired-OR bus value comes back in.

Port C presents its data together with a per-bit drive enable.

Top module: `xcvr_dual_stage`

## Requirements
- R1: The datapath is WIDTH bits wide (default 10) and never inverts. A value stored or passed by a stage appears with the same bit values at its output.
- R2: When the stage-one mode input `ab_latch_i` is 0 (register mode), a 0-to-1 change of `ab_strobe_i` seen at a clock edge loads `a_i` into the stage. The new value shows on port B after that edge, and not before it.
- R3: In register mode the stored value does not change while the strobe stays high, stays low or goes from 1 to 0.
- R4: When `ab_latch_i` is 1 (latch mode), stage one passes `a_i` to its output in the same cycle while `ab_strobe_i` is 1. Once the strobe is 0, it keeps the value `a_i` had at the last clock edge where the strobe was 1.
- R5: Stage two follows R2 to R4 with its own inputs `bc_latch_i` and `bc_strobe_i`, independently of stage one.
- R6: With `b_oe_n_i` = 1 no bit of `b_pull_o` is asserted. With `b_oe_n_i` = 0, bit i of `b_pull_o` is 1 exactly when stage-one bit i is 0.
- R7: Port B is open-drain. The block only ever requests a low, never drives a 1, and the bus value is the wired combination with any other driver on the backplane.
- R8: With `c_oe_n_i` = 1 every bit of `c_drive_o` is 0. With `c_oe_n_i` = 0 every bit is 1, and `c_data_o` carries the stage-two output.
- R9: With `route_bus_i` = 0, stage two takes the stage-one output. With `route_bus_i` = 1, it takes `b_bus_i`.
- R10: The internal tap is taken ahead of the B enable, so the path from stage one through the tap to C works while B is disabled.
- R11: While `rst_n` is 0, both stages are cleared to 0, both strobe histories are cleared, and neither output port drives. After release, data 0 is presented.
- R12: With both stages in latch mode, both strobes high and both enables active, a change on `a_i` shows on B and C in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | Port A data |
| b_bus_i | input | WIDTH | Resolved backplane value from the pads |
| b_pull_o | output | WIDTH | Per-bit request to pull the backplane low |
| c_data_o | output | WIDTH | Port C data |
| c_drive_o | output | WIDTH | Per-bit drive enable for port C |
| ab_latch_i | input | 1 | Stage-one mode: 0 register, 1 latch |
| bc_latch_i | input | 1 | Stage-two mode: 0 register, 1 latch |
| ab_strobe_i | input | 1 | Stage-one clock / latch enable |
| bc_strobe_i | input | 1 | Stage-two clock / latch enable |
| b_oe_n_i | input | 1 | Active-low enable of port B |
| c_oe_n_i | input | 1 | Active-low enable of port C |
| route_bus_i | input | 1 | Stage-two source: 0 internal tap, 1 backplane |

## Verification
A wrong stored value in stage one shows on `b_pull_o` in the cycle after the faulty edge, whenever B is enabled. With the tap selected, the same error also reaches `c_data_o` at once through a transparent stage two, or at the next rising strobe through a registered one.

A broken edge detector shows as a capture one cycle late, or as a capture on a level or a falling strobe. Either fault differs from the bench model at the very next sample.

Routing and enable faults show in the same cycle as the select change. Wired-OR contention makes a wrong pull-low request visible on C whenever the route selects the bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned DEF_WIDTH = 10;

    typedef enum logic {
        MODE_REG   = 1'b0,
        MODE_LATCH = 1'b1
    } stage_mode_e;

    typedef enum logic {
        SRC_TAP = 1'b0,
        SRC_BUS = 1'b1
    } stage_src_e;

endpackage

// File: rtl/xcvr_stage.sv
module xcvr_stage
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_i,
    input  logic             strobe_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    typedef struct packed {
        logic [WIDTH-1:0] hold;
        logic             strobe;
    } stage_st_t;

    stage_st_t   st_d, st_q;
    stage_mode_e mode;
    logic        rise;

    assign mode = stage_mode_e'(latch_i);

    always_comb begin
        st_d        = st_q;
        st_d.strobe = strobe_i;
        rise        = strobe_i & ~st_q.strobe;
        if (mode == MODE_LATCH) begin
            if (strobe_i) begin
                st_d.hold = din_i;
            end
        end else if (rise) begin
            st_d.hold = din_i;
        end
        dout_o = ((mode == MODE_LATCH) && strobe_i) ? din_i : st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_i && strobe_i && !st_q.strobe) |=> (st_q.hold == $past(din_i))); // R2
    AST_REG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_i && !(strobe_i && !st_q.strobe)) |=> $stable(st_q.hold)); // R3
    AST_LATCH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && strobe_i) |=> (st_q.hold == $past(din_i))); // R4
    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && !strobe_i) |=> $stable(st_q.hold)); // R4

endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             route_bus_i,
    input  logic [WIDTH-1:0] tap_i,
    input  logic [WIDTH-1:0] bus_i,
    output logic [WIDTH-1:0] dout_o
);

    stage_src_e src;

    assign src = stage_src_e'(route_bus_i);

    always_comb begin
        case (src)
            SRC_BUS: dout_o = bus_i;
            default: dout_o = tap_i;
        endcase
    end

endmodule

// File: rtl/xcvr_out_gate.sv
module xcvr_out_gate
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH      = DEF_WIDTH,
    parameter bit          OPEN_DRAIN = 1'b0
) (
    input  logic             en_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] pad_val_o,
    output logic [WIDTH-1:0] pad_en_o
);

    generate
        if (OPEN_DRAIN) begin : g_od
            // only a low is ever driven; a 1 releases the line
            assign pad_val_o = '0;
            assign pad_en_o  = en_i ? ~data_i : '0;
        end else begin : g_pp
            assign pad_val_o = data_i;
            assign pad_en_o  = {WIDTH{en_i}};
        end
    endgenerate

endmodule

// File: rtl/xcvr_dual_stage.sv
module xcvr_dual_stage
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_bus_i,
    output logic [WIDTH-1:0] b_pull_o,
    output logic [WIDTH-1:0] c_data_o,
    output logic [WIDTH-1:0] c_drive_o,
    input  logic             ab_latch_i,
    input  logic             bc_latch_i,
    input  logic             ab_strobe_i,
    input  logic             bc_strobe_i,
    input  logic             b_oe_n_i,
    input  logic             c_oe_n_i,
    input  logic             route_bus_i
);

    logic [WIDTH-1:0] s1_out;
    logic [WIDTH-1:0] s2_in;
    logic [WIDTH-1:0] s2_out;
    logic [WIDTH-1:0] b_pad_val;
    logic [WIDTH-1:0] b_pad_en;
    logic             b_en;
    logic             c_en;

    // enables stay inactive while reset is applied
    assign b_en = rst_n & ~b_oe_n_i;
    assign c_en = rst_n & ~c_oe_n_i;

    xcvr_stage #(.WIDTH(WIDTH)) u_stage_ab (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_i  (ab_latch_i),
        .strobe_i (ab_strobe_i),
        .din_i    (a_i),
        .dout_o   (s1_out)
    );

    xcvr_src_mux #(.WIDTH(WIDTH)) u_src (
        .route_bus_i (route_bus_i),
        .tap_i       (s1_out),
        .bus_i       (b_bus_i),
        .dout_o      (s2_in)
    );

    xcvr_stage #(.WIDTH(WIDTH)) u_stage_bc (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_i  (bc_latch_i),
        .strobe_i (bc_strobe_i),
        .din_i    (s2_in),
        .dout_o   (s2_out)
    );

    xcvr_out_gate #(.WIDTH(WIDTH), .OPEN_DRAIN(1'b1)) u_gate_b (
        .en_i      (b_en),
        .data_i    (s1_out),
        .pad_val_o (b_pad_val),
        .pad_en_o  (b_pad_en)
    );

    xcvr_out_gate #(.WIDTH(WIDTH), .OPEN_DRAIN(1'b0)) u_gate_c (
        .en_i      (c_en),
        .data_i    (s2_out),
        .pad_val_o (c_data_o),
        .pad_en_o  (c_drive_o)
    );

    assign b_pull_o = b_pad_en & ~b_pad_val;

    AST_TAP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !route_bus_i |-> (s2_in == s1_out)); // R9
    AST_BUS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        route_bus_i |-> (s2_in == b_bus_i)); // R9
    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_pull_o & s1_out) == '0)); // R7
    AST_B_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe_n_i |-> (b_pull_o == '0)); // R6
    AST_C_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        c_oe_n_i |-> (c_drive_o == '0)); // R8

    always_comb begin
        if (rst_n == 1'b0) begin
            AST_RST_QUIET: assert ((b_pull_o == '0) && (c_drive_o == '0)); // R11
        end
    end

endmodule

// File: tb/xcvr_dual_stage_bench.sv
module xcvr_dual_stage_bench;

    localparam int W = 10;
    localparam logic [W-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] other = '0;
    logic         lat1 = 1'b0, lat2 = 1'b0, st1 = 1'b0, st2 = 1'b0;
    logic         b_oe_n = 1'b0, c_oe_n = 1'b0, sel = 1'b0;
    logic [W-1:0] b_pull, c_data, c_drive;
    wire  [W-1:0] b_bus = ~(b_pull | other);

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] m1, m2;
    logic         p1, p2;

    always #5 clk = ~clk;

    xcvr_dual_stage #(.WIDTH(W)) u_xcvr_dual_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_i         (a),
        .b_bus_i     (b_bus),
        .b_pull_o    (b_pull),
        .c_data_o    (c_data),
        .c_drive_o   (c_drive),
        .ab_latch_i  (lat1),
        .bc_latch_i  (lat2),
        .ab_strobe_i (st1),
        .bc_strobe_i (st2),
        .b_oe_n_i    (b_oe_n),
        .c_oe_n_i    (c_oe_n),
        .route_bus_i (sel)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [W-1:0] ref_s1();
        return (lat1 && st1) ? a : m1;
    endfunction

    function automatic logic [W-1:0] ref_pull();
        return (b_oe_n || !rst_n) ? '0 : ~ref_s1();
    endfunction

    function automatic logic [W-1:0] ref_s2in();
        logic [W-1:0] bus;
        bus = ~(ref_pull() | other);
        return sel ? bus : ref_s1();
    endfunction

    function automatic logic [W-1:0] ref_c();
        return (lat2 && st2) ? ref_s2in() : m2;
    endfunction

    task automatic model_tick();
        logic [W-1:0] n1, n2;
        n1 = m1;
        n2 = m2;
        if (lat1) begin
            if (st1) n1 = a;
        end else if (st1 && !p1) begin
            n1 = a;
        end
        if (lat2) begin
            if (st2) n2 = ref_s2in();
        end else if (st2 && !p2) begin
            n2 = ref_s2in();
        end
        tick();
        m1 = n1;
        m2 = n2;
        p1 = st1;
        p2 = st2;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        logic [31:0]  x;
        // R11: reset quiet
        repeat (3) tick();
        chk("R11 b quiet in reset", b_pull, '0);
        chk("R11 c quiet in reset", c_drive, '0);
        rst_n = 1'b1;
        #1;
        chk("R11 cleared stage one shows as all pulled low", b_pull, ALL);
        chk("R11 c enabled after release", c_drive, ALL);
        chk("R11 cleared stage two", c_data, '0);

        // R2: register capture on rising strobe only
        a = 10'h2A5;
        st1 = 1'b1;
        #1;
        chk("R2 no update before edge", b_pull, ALL);
        tick();
        chk("R2 captured after rising strobe", b_pull, 10'h15A);
        chk("R1 stage two untouched", c_data, '0);

        // R3: level high, falling and low do not update
        a = 10'h0F0;
        tick();
        tick();
        chk("R3 held with strobe high", b_pull, 10'h15A);
        st1 = 1'b0;
        tick();
        chk("R3 held on falling strobe", b_pull, 10'h15A);
        tick();
        chk("R3 held with strobe low", b_pull, 10'h15A);

        // R5 and R9: stage two registers the internal tap
        st2 = 1'b1;
        tick();
        chk("R5 stage two captured tap", c_data, 10'h2A5);

        // R4: latch mode transparency and hold
        lat1 = 1'b1;
        #1;
        chk("R4 latch low keeps stored", b_pull, 10'h15A);
        st1 = 1'b1;
        a = 10'h155;
        #1;
        chk("R4 transparent while high", b_pull, 10'h2AA);
        a = 10'h0C3;
        #1;
        chk("R4 follows input change", b_pull, 10'h33C);
        tick();
        st1 = 1'b0;
        a = 10'h3FF;
        #1;
        chk("R4 holds after strobe falls", b_pull, 10'h33C);
        tick();
        chk("R4 still held next cycle", b_pull, 10'h33C);

        // R6 and R10: B disabled, tap still reaches C
        b_oe_n = 1'b1;
        lat2 = 1'b1;
        #1;
        chk("R6 no pull when disabled", b_pull, '0);
        chk("R10 tap to C with B off", c_data, 10'h0C3);
        st1 = 1'b1;
        a = 10'h1E1;
        #1;
        chk("R10 transparent chain with B off", c_data, 10'h1E1);

        // R9: bus route with another driver only
        sel = 1'b1;
        other = 10'h00F;
        #1;
        chk("R9 C sees backplane", c_data, 10'h3F0);

        // R7: wired-OR contention
        b_oe_n = 1'b0;
        #1;
        chk("R7 pull requests only zeros", b_pull, 10'h21E);
        chk("R7 wired bus value at C", c_data, 10'h1E0);

        // R8: C enable
        c_oe_n = 1'b1;
        #1;
        chk("R8 C released", c_drive, '0);
        c_oe_n = 1'b0;
        #1;
        chk("R8 C driven", c_drive, ALL);

        // R12: buffer mode
        other = '0;
        a = 10'h36C;
        #1;
        chk("R12 B follows A at once", b_pull, 10'h093);
        chk("R12 C follows A at once", c_data, 10'h36C);

        // R5: stage two register mode independent of stage one
        lat2 = 1'b0;
        st2 = 1'b0;
        tick();
        tick();
        held = c_data;
        a = 10'h011;
        #1;
        chk("R5 stage one moved", b_pull, 10'h3EE);
        tick();
        chk("R5 stage two held without its edge", c_data, held);
        st2 = 1'b1;
        tick();
        chk("R5 stage two captured on its edge", c_data, 10'h011);

        // sweep all mode and route configurations against the model
        rst_n = 1'b0;
        st1 = 1'b0;
        st2 = 1'b0;
        tick();
        rst_n = 1'b1;
        m1 = '0;
        m2 = '0;
        p1 = 1'b0;
        p2 = 1'b0;
        x = 32'h1234_5678;
        for (int cfg = 0; cfg < 8; cfg++) begin
            lat1 = cfg[0];
            lat2 = cfg[1];
            sel  = cfg[2];
            for (int s = 0; s < 64; s++) begin
                x = x * 32'd1664525 + 32'd1013904223;
                a      = x[W-1:0];
                st1    = x[11];
                st2    = x[13];
                b_oe_n = x[14] & x[15];
                c_oe_n = x[28] & x[29];
                other  = x[17] ? '0 : x[27:18];
                #1;
                chk("R7 sweep B pull", b_pull, ref_pull());
                chk("R5 sweep C data", c_data, ref_c());
                chk("R8 sweep C drive", c_drive, c_oe_n ? '0 : ALL);
                model_tick();
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule